// File: doc/BRIEF.md
# ADC Conversion Trigger Scheduler

This block decides when each of sixteen sample slots may start an analog-to-digital conversion, and hands those starts one at a time to a single converter. Each slot keeps its own configuration: a 4-bit code naming which external event starts it, an 8-bit delay count, and a 2-bit code choosing how many clock cycles make up one delay tick. When the chosen event pulses, the slot waits out its delay and then raises its pending bit. A write of a software mask can start any set of slots in one cycle.

A fixed-priority arbiter picks the lowest-numbered pending slot, pulses `conv_start` with that slot's index, and waits for `conv_done`. Only then does that slot's pending bit drop, and the arbiter looks again. A trigger that reaches a slot which is already waiting or pending is not queued; it sets a sticky per-slot overrun bit instead. A control-reset request runs a short sequence that clears all run-time state and keeps the configuration.

Top module: `adc_trig_sched`

## Requirements
- R1: A slot with source code k in 1..15 is triggered by a one-cycle pulse on `evt_in[k]`. Pulses on any other bit of `evt_in` do nothing to it. Code 0 means no hardware source, so `evt_in[0]` never has any effect.
- R2: When `sw_we` is high, every slot i with `sw_mask[i]`=1 sees a trigger in that cycle, whatever its source code. Several slots may start in the same cycle.
- R3: Divider code 0, 1, 2 and 3 gives a tick of 1, 2, 4 and 16 clock cycles. For a delay count D greater than 0, the pending bit rises D×tick cycles after the clock edge that samples the trigger.
- R4: With a delay count of 0, the pending bit is set at the same edge that samples the trigger, so it reads 1 in the next cycle.
- R5: A pending bit stays at 1 until that slot's conversion ends. It clears at the edge that samples `conv_done` for the granted slot.
- R6: When the converter is free, the lowest-numbered pending slot is granted. `conv_start` is a one-cycle pulse and carries the index on `conv_slot`. Only one conversion runs at a time, and the next grant can follow only after `conv_done`.
- R7: A trigger that reaches a slot which is waiting or pending sets that slot's `start_ovf` bit. The bit stays set until a control reset, and no second conversion is queued.
- R8: `ovf_any` is 1 exactly when at least one `start_ovf` bit is 1.
- R9: A one-cycle `rst_req` raises `rst_busy` for RST_CYC cycles (default 4). During that time the pending bits, overrun bits and running delays are cleared, and `rst_busy` then drops by itself. Slot configuration is kept.
- R10: A cycle with `cfg_we` high loads `cfg_src`, `cfg_dly` and `cfg_div` into slot `cfg_slot`. The new values apply to triggers from the next cycle on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Converter clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Write strobe for one slot's configuration |
| cfg_slot | input | 4 | Slot that is written |
| cfg_src | input | 4 | Trigger source code (0 means software only) |
| cfg_dly | input | 8 | Delay count in ticks |
| cfg_div | input | 2 | Tick length code: 1, 2, 4 or 16 cycles |
| sw_we | input | 1 | Software start strobe |
| sw_mask | input | 16 | Slots to start when `sw_we` is high |
| evt_in | input | 16 | Hardware trigger pulses, indexed by source code |
| rst_req | input | 1 | Starts the control-reset sequence |
| conv_done | input | 1 | Converter finished the granted conversion |
| conv_start | output | 1 | One-cycle start pulse to the converter |
| conv_slot | output | 4 | Slot granted with `conv_start` |
| pend | output | 16 | Per-slot pending bits |
| start_ovf | output | 16 | Per-slot sticky start-overrun bits |
| ovf_any | output | 1 | OR of all start-overrun bits |
| rst_busy | output | 1 | High while the control reset runs |

## Verification
The bench measures the exact cycle at which the pending bit rises for every divider code and for a zero delay. A design off by one tick, or one that ignores the divider code, raises the bit one cycle early or late. It starts three slots with one software write and checks that the grants come out in ascending order, which a wrong priority encoder would break. It retriggers a slot while that slot waits, and expects exactly one conversion and a sticky overrun bit; a design that queued the second trigger would produce an extra grant. It also fires `evt_in[0]` and sources that no slot has selected, expecting no effect. Finally it runs a control reset over a pending delay and expects the delay to be dropped and the configuration kept.

// File: rtl/adc_trig_pkg.sv
package adc_trig_pkg;

   typedef enum logic [1:0] {
      TICK_1  = 2'd0,
      TICK_2  = 2'd1,
      TICK_4  = 2'd2,
      TICK_16 = 2'd3
   } tick_sel_e;

   // log2 of the number of clock cycles in one delay tick
   function automatic int unsigned tick_shift(tick_sel_e sel);
      case (sel)
         TICK_1:  return 0;
         TICK_2:  return 1;
         TICK_4:  return 2;
         default: return 4;
      endcase
   endfunction

endpackage

// File: rtl/trg_slot.sv
module trg_slot
   import adc_trig_pkg::*;
#(
   parameter int NSRC = 16,
   parameter int DLYW = 8
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    hold,
   input  logic                    cfg_we,
   input  logic [$clog2(NSRC)-1:0] cfg_src,
   input  logic [DLYW-1:0]         cfg_dly,
   input  tick_sel_e               cfg_div,
   input  logic [NSRC-1:0]         evt_in,
   input  logic                    sw_hit,
   input  logic                    done_hit,
   output logic                    pend,
   output logic                    ovf
);
   localparam int SW = $clog2(NSRC);
   localparam int CW = DLYW + 4;

   logic [SW-1:0]   src_q;
   logic [DLYW-1:0] dly_q;
   tick_sel_e       div_q;
   logic            wait_q;
   logic [CW-1:0]   cnt_q;
   logic            fire;
   logic [CW-1:0]   load;

   assign fire = sw_hit | ((src_q != '0) & evt_in[src_q]);
   assign load = CW'(dly_q) << tick_shift(div_q);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         src_q  <= '0;
         dly_q  <= '0;
         div_q  <= TICK_1;
         wait_q <= 1'b0;
         cnt_q  <= '0;
         pend   <= 1'b0;
         ovf    <= 1'b0;
      end else begin
         if (cfg_we) begin
            src_q <= cfg_src;
            dly_q <= cfg_dly;
            div_q <= cfg_div;
         end
         if (hold) begin
            wait_q <= 1'b0;
            cnt_q  <= '0;
            pend   <= 1'b0;
            ovf    <= 1'b0;
         end else begin
            if (done_hit) pend <= 1'b0;
            if (wait_q) begin
               if (cnt_q == CW'(1)) begin
                  pend   <= 1'b1;
                  wait_q <= 1'b0;
               end else begin
                  cnt_q <= cnt_q - CW'(1);
               end
            end
            if (fire) begin
               if (pend | wait_q) begin
                  ovf <= 1'b1;
               end else if (load == '0) begin
                  pend <= 1'b1;
               end else begin
                  wait_q <= 1'b1;
                  cnt_q  <= load;
               end
            end
         end
      end
   end

   assert_pend_held_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (pend && !done_hit && !hold) |=> pend);
   assert_ovf_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (ovf && !hold) |=> ovf);
   assert_zero_delay_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (fire && !pend && !wait_q && !hold && load == '0) |=> pend);
   assert_hold_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
      hold |=> (!pend && !ovf && !wait_q));
endmodule

// File: rtl/trg_arb.sv
module trg_arb #(
   parameter int N = 16
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 hold,
   input  logic [N-1:0]         req,
   input  logic                 done,
   output logic                 start,
   output logic [$clog2(N)-1:0] gslot,
   output logic [N-1:0]         done_vec
);
   localparam int IW = $clog2(N);

   logic          busy_q;
   logic          found;
   logic [IW-1:0] low_idx;

   always_comb begin
      found   = 1'b0;
      low_idx = '0;
      for (int i = N - 1; i >= 0; i--) begin
         if (req[i]) begin
            found   = 1'b1;
            low_idx = IW'(i);
         end
      end
   end

   assign done_vec = (busy_q && done && !hold) ? (N'(1) << gslot) : '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q <= 1'b0;
         start  <= 1'b0;
         gslot  <= '0;
      end else if (hold) begin
         busy_q <= 1'b0;
         start  <= 1'b0;
      end else begin
         start <= 1'b0;
         if (busy_q) begin
            if (done) busy_q <= 1'b0;
         end else if (found) begin
            busy_q <= 1'b1;
            start  <= 1'b1;
            gslot  <= low_idx;
         end
      end
   end

   assert_start_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
      start |=> !start);
   assert_grant_pending_R6: assert property (@(posedge clk) disable iff (!rst_n)
      start |-> req[gslot]);
   assert_grant_lowest_R6: assert property (@(posedge clk) disable iff (!rst_n)
      start |-> (($past(req) & ((N'(1) << gslot) - N'(1))) == '0));
   assert_grant_stable_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_q && !done && !hold) |=> $stable(gslot));
endmodule

// File: rtl/trg_rstseq.sv
module trg_rstseq #(
   parameter int RST_CYC = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic req,
   output logic busy
);
   localparam int CW = (RST_CYC > 1) ? $clog2(RST_CYC) : 1;

   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy  <= 1'b0;
         cnt_q <= '0;
      end else if (busy) begin
         if (cnt_q == '0) busy <= 1'b0;
         else             cnt_q <= cnt_q - CW'(1);
      end else if (req) begin
         busy  <= 1'b1;
         cnt_q <= CW'(RST_CYC - 1);
      end
   end

   assert_rst_runs_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && cnt_q != '0) |=> busy);
   assert_rst_ends_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && cnt_q == '0) |=> !busy);
endmodule

// File: rtl/adc_trig_sched.sv
module adc_trig_sched
   import adc_trig_pkg::*;
#(
   parameter int NSLOT   = 16,
   parameter int NSRC    = 16,
   parameter int DLYW    = 8,
   parameter int RST_CYC = 4
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     cfg_we,
   input  logic [$clog2(NSLOT)-1:0] cfg_slot,
   input  logic [$clog2(NSRC)-1:0]  cfg_src,
   input  logic [DLYW-1:0]          cfg_dly,
   input  logic [1:0]               cfg_div,
   input  logic                     sw_we,
   input  logic [NSLOT-1:0]         sw_mask,
   input  logic [NSRC-1:0]          evt_in,
   input  logic                     rst_req,
   input  logic                     conv_done,
   output logic                     conv_start,
   output logic [$clog2(NSLOT)-1:0] conv_slot,
   output logic [NSLOT-1:0]         pend,
   output logic [NSLOT-1:0]         start_ovf,
   output logic                     ovf_any,
   output logic                     rst_busy
);
   localparam int IW = $clog2(NSLOT);

   if (NSLOT < 2 || (1 << IW) != NSLOT) begin : g_bad_nslot
      $error("NSLOT must be a power of two, at least 2");
   end
   if (NSRC < 2 || (1 << $clog2(NSRC)) != NSRC) begin : g_bad_nsrc
      $error("NSRC must be a power of two, at least 2");
   end
   if (DLYW < 1 || RST_CYC < 1) begin : g_bad_len
      $error("DLYW and RST_CYC must be at least 1");
   end

   logic [NSLOT-1:0] done_vec;
   tick_sel_e        div_sel;

   assign div_sel = tick_sel_e'(cfg_div);
   assign ovf_any = |start_ovf;

   trg_rstseq #(.RST_CYC(RST_CYC)) u_rstseq (
      .clk  (clk),
      .rst_n(rst_n),
      .req  (rst_req),
      .busy (rst_busy)
   );

   for (genvar s = 0; s < NSLOT; s++) begin : g_slot
      trg_slot #(.NSRC(NSRC), .DLYW(DLYW)) u_slot (
         .clk     (clk),
         .rst_n   (rst_n),
         .hold    (rst_busy),
         .cfg_we  (cfg_we && (cfg_slot == IW'(s))),
         .cfg_src (cfg_src),
         .cfg_dly (cfg_dly),
         .cfg_div (div_sel),
         .evt_in  (evt_in),
         .sw_hit  (sw_we & sw_mask[s]),
         .done_hit(done_vec[s]),
         .pend    (pend[s]),
         .ovf     (start_ovf[s])
      );
   end

   trg_arb #(.N(NSLOT)) u_arb (
      .clk     (clk),
      .rst_n   (rst_n),
      .hold    (rst_busy),
      .req     (pend),
      .done    (conv_done),
      .start   (conv_start),
      .gslot   (conv_slot),
      .done_vec(done_vec)
   );

   assert_ovf_any_rise_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ovf_any) |-> $past(start_ovf) == '0);
endmodule

// File: tb/test_adc_trig_sched.sv
`timescale 1ns/1ps
module test_adc_trig_sched;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_we = 1'b0;
   logic [3:0]  cfg_slot = '0;
   logic [3:0]  cfg_src = '0;
   logic [7:0]  cfg_dly = '0;
   logic [1:0]  cfg_div = '0;
   logic        sw_we = 1'b0;
   logic [15:0] sw_mask = '0;
   logic [15:0] evt_in = '0;
   logic        rst_req = 1'b0;
   logic        conv_done = 1'b0;
   logic        conv_start;
   logic [3:0]  conv_slot;
   logic [15:0] pend;
   logic [15:0] start_ovf;
   logic        ovf_any;
   logic        rst_busy;

   int n_chk = 0;
   int n_bad = 0;
   bit ended = 0;
   int exp_q[$];

   always #2.5 clk = ~clk;

   adc_trig_sched i_adc_trig_sched (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_slot(cfg_slot),
      .cfg_src(cfg_src), .cfg_dly(cfg_dly), .cfg_div(cfg_div),
      .sw_we(sw_we), .sw_mask(sw_mask), .evt_in(evt_in), .rst_req(rst_req),
      .conv_done(conv_done), .conv_start(conv_start), .conv_slot(conv_slot),
      .pend(pend), .start_ovf(start_ovf), .ovf_any(ovf_any), .rst_busy(rst_busy)
   );

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   task automatic tick(input int n = 1);
      repeat (n) @(negedge clk);
   endtask

   task automatic set_cfg(input int slot, input int src, input int dly, input int div);
      cfg_slot = 4'(slot); cfg_src = 4'(src); cfg_dly = 8'(dly); cfg_div = 2'(div);
      cfg_we = 1'b1;
      tick();
      cfg_we = 1'b0;
   endtask

   task automatic pulse_evt(input int k);
      evt_in = 16'(1) << k;
      tick();
      evt_in = '0;
   endtask

   // configure, trigger, and find the cycle the pending bit rises
   task automatic measure(input string tag, input int slot, input int src,
                          input int dly, input int div, input int lat);
      set_cfg(slot, src, dly, div);
      exp_q.push_back(slot);
      pulse_evt(src);
      if (lat > 0) begin
         tick(lat - 1);
         check({tag, " pend still low"}, 32'(pend[slot]), 0);
         tick();
      end
      check({tag, " pend rises"}, 32'(pend[slot]), 1);
      tick(14);
   endtask

   // scoreboard monitor: compare each grant, then answer it with a done pulse
   initial begin
      forever begin
         @(negedge clk);
         if (conv_start) begin
            if (exp_q.size() == 0) begin
               check("R6 unexpected grant", 32'(conv_slot), 32'hFFFF);
            end else begin
               check("R6 grant order", 32'(conv_slot), 32'(exp_q.pop_front()));
            end
            tick(2);
            conv_done = 1'b1;
            tick();
            conv_done = 1'b0;
         end
      end
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!ended) begin
         ended = 1;
         n_chk++; n_bad++;
         $display("FAIL watchdog: actual running expected finished");
         $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
         $finish;
      end
   end

   initial begin
      tick(3);
      rst_n = 1'b1;
      tick();
      check("R6 reset conv_start", 32'(conv_start), 0);
      check("R5 reset pend", 32'(pend), 0);
      check("R7 reset start_ovf", 32'(start_ovf), 0);
      check("R9 reset rst_busy", 32'(rst_busy), 0);

      // R3/R10: each divider code, exact rise cycle
      measure("R3 tick1", 1, 4, 5, 0, 5);
      measure("R3 tick2", 10, 5, 3, 1, 6);
      measure("R3 tick4", 12, 9, 2, 2, 8);
      measure("R3 tick16 R10", 14, 15, 2, 3, 32);

      // R4 zero delay, R5 pending held through conversion
      set_cfg(6, 3, 0, 3);
      exp_q.push_back(6);
      pulse_evt(3);
      check("R4 zero delay pend", 32'(pend[6]), 1);
      tick(3);
      check("R5 held during conversion", 32'(pend[6]), 1);
      tick();
      check("R5 cleared on done", 32'(pend[6]), 0);
      tick(10);

      // R1: unselected source and evt_in[0] have no effect
      pulse_evt(6);
      pulse_evt(0);
      tick(40);
      check("R1 no effect from unused sources", 32'(pend), 0);

      // R2 + R6: one software write starts three slots, lowest first
      exp_q.push_back(2); exp_q.push_back(5); exp_q.push_back(9);
      sw_mask = 16'h0224; sw_we = 1'b1;
      tick();
      sw_we = 1'b0; sw_mask = '0;
      check("R2 software mask sets pend", 32'(pend), 32'h0224);
      tick(30);
      check("R6 all grants served", 32'(pend), 0);
      check("R6 queue drained", 32'(exp_q.size()), 0);

      // R7/R8: retrigger during delay
      set_cfg(12, 7, 10, 0);
      exp_q.push_back(12);
      check("R8 ovf_any low before", 32'(ovf_any), 0);
      pulse_evt(7);
      tick(2);
      pulse_evt(7);
      check("R7 overrun bit", 32'(start_ovf), 32'h1000);
      check("R8 ovf_any high", 32'(ovf_any), 1);
      tick(30);
      check("R7 single conversion", 32'(exp_q.size()), 0);
      check("R7 overrun sticky", 32'(start_ovf[12]), 1);

      // R9: control reset drops a running delay and the overrun, keeps config
      set_cfg(3, 8, 20, 0);
      pulse_evt(8);
      rst_req = 1'b1;
      tick();
      rst_req = 1'b0;
      begin
         int busy_n = 0;
         while (rst_busy && busy_n < 20) begin
            busy_n++;
            tick();
         end
         check("R9 busy length", 32'(busy_n), 4);
      end
      check("R9 overrun cleared", 32'(start_ovf), 0);
      check("R8 ovf_any cleared", 32'(ovf_any), 0);
      tick(30);
      check("R9 delay dropped", 32'(pend), 0);
      exp_q.push_back(3);
      pulse_evt(8);
      tick(19);
      check("R9 config kept, still waiting", 32'(pend[3]), 0);
      tick();
      check("R9 config kept, pend rises", 32'(pend[3]), 1);
      tick(15);
      check("R6 final queue empty", 32'(exp_q.size()), 0);

      if (!ended) begin
         ended = 1;
         $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
         $finish;
      end
   end
endmodule